// File: doc/BRIEF.md
# PC/104 Memory Window Decoder

This block sits on the slave side of an ISA-style PC/104 bus and listens for accesses to one fixed 64 KB memory window, 0xD0000 through 0xDFFFF. The address is latched while the address-latch strobe is high, together with the address-enable level. The active-low read and write strobes come from the bus with no clock relation, so they pass through a two-stage synchronizer. A request fires on the detected falling edge of either strobe. Each claimed access becomes a single-cycle request on an internal 16-bit register port. That port carries a word offset, a write pulse with write data, and a read pulse whose data comes back one cycle later.

A write captures the word offset and the bus data on the same clock edge. A read pulls the ready line low for a parameterised number of wait cycles, which covers the read-data return. The returned word is held in a register and driven onto the data bus only while a claimed read strobe is low. Outside that time the data bus is left at high impedance.

Top module: `pc104_win_dec`

## Requirements
- R1: After reset, bus_ready is 1, reg_we and reg_re are 0, and bus_data is not driven.
- R2: An access is claimed only when the latched address has bits [19:16] equal to 0xD, which is the window 0xD0000–0xDFFFF. Accesses outside the window produce no request.
- R3: An access is ignored if bus_aen was high while the address was latched.
- R4: A strobe produces a request only if bus_ale has been high since the previous strobe. A strobe without a fresh address phase is ignored.
- R5: On a claimed write, reg_we is high for exactly one cycle, starting at the third rising clock edge at which bus_iow_n is sampled low. On that same edge, reg_off takes address bits [15:1] and reg_wdata takes bus_data.
- R6: On a claimed read, reg_re is high for exactly one cycle, starting at the third rising edge at which bus_ior_n is sampled low, with reg_off equal to address bits [15:1]. reg_re and reg_we are never high together.
- R7: bus_ready goes low on the edge that raises reg_re. It returns high WAIT_CYC edges later (at least 2). It never goes low for any other reason.
- R8: The reg_rdata value present in the cycle after reg_re is the value driven on bus_data while the read strobe is still low and bus_ready is high.
- R9: bus_data is driven only while bus_ior_n is low during a claimed read. At all other times it is high impedance.
- R10: A strobe held low for any length of time produces exactly one request.
- R11: Odd addresses (address bit 0 = 1) are not claimed, because the port carries only 16-bit words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 20 | Bus address lines |
| bus_ale | input | 1 | Address latch strobe, active high |
| bus_aen | input | 1 | Address enable; high marks a cycle this slave must ignore |
| bus_ior_n | input | 1 | Read strobe, active low |
| bus_iow_n | input | 1 | Write strobe, active low |
| bus_data | inout | 16 | Bidirectional data bus |
| bus_ready | output | 1 | Channel ready; low inserts wait states |
| reg_off | output | 15 | Word offset inside the window |
| reg_we | output | 1 | One-cycle write request |
| reg_wdata | output | 16 | Write data |
| reg_re | output | 1 | One-cycle read request |
| reg_rdata | input | 16 | Read data, valid the cycle after reg_re |

## Verification
The hardest condition to reach from the ports is a strobe that arrives with no new address phase. After a claimed access, the decoder still holds an address that matches the window, so a bare strobe looks valid unless the consumed-address rule is enforced. The stimulus issues a normal window write and then a strobe with the latch line kept low, and expects no request. A strobe held low for forty cycles checks that only one request fires per strobe. The bench drives the read return one cycle late and puts junk on the return lines in every other cycle, so a capture taken one cycle early or late shows up as wrong bus data.

// File: rtl/pc104_win_dec.sv
module pc104_win_dec #(
  parameter int          WAIT_CYC = 3,
  parameter logic [3:0]  WIN_SEL  = 4'hD
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [19:0] bus_addr,
  input  logic        bus_ale,
  input  logic        bus_aen,
  input  logic        bus_ior_n,
  input  logic        bus_iow_n,
  inout  wire  [15:0] bus_data,
  output logic        bus_ready,
  output logic [14:0] reg_off,
  output logic        reg_we,
  output logic [15:0] reg_wdata,
  output logic        reg_re,
  input  logic [15:0] reg_rdata
);

  localparam int WAIT_EFF = (WAIT_CYC < 2) ? 2 : WAIT_CYC;
  localparam int CNT_W    = $clog2(WAIT_EFF + 1);

  logic [19:0]      addr_q;
  logic             aen_q;
  logic             ale_seen;
  logic [2:0]       ior_sh;
  logic [2:0]       iow_sh;
  logic             take;
  logic             rd_claim;
  logic [15:0]      rd_q;
  logic [CNT_W-1:0] wcnt;

  wire ior_fall = ior_sh[2] & ~ior_sh[1];
  wire iow_fall = iow_sh[2] & ~iow_sh[1];
  wire hit      = ale_seen & ~aen_q & (addr_q[19:16] == WIN_SEL) & ~addr_q[0];
  wire wr_go    = iow_fall & hit;
  wire rd_go    = ior_fall & hit & ~wr_go;
  wire drv      = rd_claim & ~bus_ior_n;

  assign bus_data  = drv ? rd_q : 16'bz;
  assign bus_ready = (wcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ior_sh <= 3'b111;
      iow_sh <= 3'b111;
    end else begin
      ior_sh <= {ior_sh[1:0], bus_ior_n};
      iow_sh <= {iow_sh[1:0], bus_iow_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      aen_q    <= 1'b1;
      ale_seen <= 1'b0;
    end else if (bus_ale) begin
      addr_q   <= bus_addr;
      aen_q    <= bus_aen;
      ale_seen <= 1'b1;
    end else if (ior_fall | iow_fall) begin
      ale_seen <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we    <= 1'b0;
      reg_re    <= 1'b0;
      take      <= 1'b0;
      reg_off   <= '0;
      reg_wdata <= '0;
      rd_q      <= '0;
    end else begin
      reg_we <= wr_go;
      reg_re <= rd_go;
      take   <= reg_re;
      if (wr_go | rd_go) reg_off <= addr_q[15:1];
      if (wr_go) reg_wdata <= bus_data;
      if (take) rd_q <= reg_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_claim <= 1'b0;
      wcnt     <= '0;
    end else begin
      if (rd_go) rd_claim <= 1'b1;
      else if (ior_sh[1]) rd_claim <= 1'b0;
      if (rd_go) wcnt <= CNT_W'(WAIT_EFF);
      else if (wcnt != '0) wcnt <= wcnt - 1'b1;
    end
  end

endmodule

// File: rtl/pc104_win_dec_chk.sv
module pc104_win_dec_chk (
  input logic clk,
  input logic rst_n,
  input logic reg_we,
  input logic reg_re,
  input logic bus_ready
);

  // R6
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(reg_we && reg_re));

  // R10
  we_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_we |=> !reg_we);

  // R10
  re_single_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_re |=> !reg_re);

  // R7
  re_holds_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) reg_re |-> !bus_ready);

  // R7
  ready_drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(bus_ready) |-> reg_re);

endmodule

bind pc104_win_dec pc104_win_dec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re), .bus_ready(bus_ready)
);

// File: tb/test_pc104_win_dec.sv
module test_pc104_win_dec;
  localparam int WE = 3;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [19:0] bus_addr = '0;
  logic        bus_ale = 0, bus_aen = 1, bus_ior_n = 1, bus_iow_n = 1;
  wire  [15:0] bus_data;
  logic        bus_ready, reg_we, reg_re;
  logic [14:0] reg_off;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata = 16'hDEAD;
  logic        tb_den = 0;
  logic [15:0] tb_d = '0;

  int checks = 0, failures = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0, prev_re = 0;

  always #4 clk = ~clk;

  assign bus_data = tb_den ? tb_d : 16'bz;
  for (genvar g = 0; g < 16; g++) begin : g_pu
    pullup (bus_data[g]);
  end

  pc104_win_dec #(.WAIT_CYC(WE)) i_pc104_win_dec (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_ale(bus_ale), .bus_aen(bus_aen),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_data(bus_data), .bus_ready(bus_ready),
    .reg_off(reg_off), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_re(reg_re),
    .reg_rdata(reg_rdata)
  );

  function automatic logic [15:0] pat(input logic [14:0] off);
    return {1'b0, off} ^ 16'h2A5C;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model, updated at each rising edge
  int          lowR = 0, lowW = 0, wc = 0, rt = 0;
  bit          m_seen = 0, m_aen = 1, m_we = 0, m_re = 0, m_claim = 0;
  logic [19:0] m_addr = '0;
  logic [14:0] m_off = '0;
  logic [15:0] m_wd = '0, m_rd = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      lowR = 0; lowW = 0; wc = 0; rt = 0; m_seen = 0; m_aen = 1;
      m_we = 0; m_re = 0; m_claim = 0;
    end else begin
      bit fR, fW, hit;
      lowR = bus_ior_n ? 0 : lowR + 1;
      lowW = bus_iow_n ? 0 : lowW + 1;
      fR = (lowR == 3);
      fW = (lowW == 3);
      hit = m_seen && !m_aen && (m_addr[19:16] == 4'hD) && !m_addr[0];
      m_we = fW && hit;
      m_re = fR && hit && !m_we;
      if (m_we || m_re) m_off = m_addr[15:1];
      if (m_we) m_wd = bus_data;
      if (bus_ale) begin m_addr = bus_addr; m_aen = bus_aen; m_seen = 1; end
      else if (fR || fW) m_seen = 0;
      if (m_re) m_claim = 1; else if (bus_ior_n) m_claim = 0;
      if (m_re) wc = WE; else if (wc > 0) wc--;
      if (m_re) rt = 2;
      else if (rt > 0) begin rt--; if (rt == 0) m_rd = pat(m_off); end
    end
  end

  // read-return emulation: valid data only in the cycle after reg_re
  always @(negedge clk) begin
    reg_rdata <= prev_re ? pat(reg_off) : 16'hDEAD;
    prev_re = reg_re;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (reg_we) we_cnt++;
      if (reg_re) re_cnt++;
      chk(reg_we == m_we, "R5 reg_we", 32'(reg_we), 32'(m_we));
      chk(reg_re == m_re, "R6 reg_re", 32'(reg_re), 32'(m_re));
      chk(bus_ready == (wc == 0), "R7 bus_ready", 32'(bus_ready), 32'(wc == 0));
      if (m_we) begin
        chk(reg_off == m_off, "R5 reg_off", 32'(reg_off), 32'(m_off));
        chk(reg_wdata == m_wd, "R5 reg_wdata", 32'(reg_wdata), 32'(m_wd));
      end
      if (m_re) chk(reg_off == m_off, "R6 reg_off", 32'(reg_off), 32'(m_off));
      if (!bus_ior_n && m_claim) begin
        if (bus_ready) chk(bus_data == m_rd, "R8 bus_data", 32'(bus_data), 32'(m_rd));
      end else if (!tb_den) begin
        chk(bus_data == 16'hFFFF, "R9 bus_data undriven", 32'(bus_data), 32'hFFFF);
      end
    end
  end

  task automatic bus_cycle(input logic [19:0] a, input bit aen, input bit ale, input bit wr,
                           input logic [15:0] d, input int lowc, input int expn, input string req);
    int b_we, b_re;
    b_we = we_cnt; b_re = re_cnt;
    @(negedge clk); bus_addr = a; bus_aen = aen; bus_ale = ale;
    @(negedge clk); bus_ale = 0;
    @(negedge clk);
    if (wr) begin tb_den = 1; tb_d = d; bus_iow_n = 0; end
    else bus_ior_n = 0;
    repeat (lowc) @(negedge clk);
    bus_iow_n = 1; bus_ior_n = 1;
    @(negedge clk); tb_den = 0;
    repeat (5) @(negedge clk);
    if (wr) chk(we_cnt - b_we == expn, req, 32'(we_cnt - b_we), 32'(expn));
    else    chk(re_cnt - b_re == expn, req, 32'(re_cnt - b_re), 32'(expn));
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk(bus_ready == 1'b1, "R1 ready", 32'(bus_ready), 1);
    chk(reg_we == 0 && reg_re == 0, "R1 requests", {30'b0, reg_we, reg_re}, 0);
    chk(bus_data == 16'hFFFF, "R1 bus_data", 32'(bus_data), 32'hFFFF);

    bus_cycle(20'hD0010, 0, 1, 1, 16'h1234, 8, 1, "R5 window write");
    bus_cycle(20'hD0022, 0, 1, 0, 16'h0, 8, 1, "R6 window read");
    bus_cycle(20'hD0000, 0, 1, 1, 16'h0F0F, 8, 1, "R2 low edge write");
    bus_cycle(20'hDFFFE, 0, 1, 0, 16'h0, 8, 1, "R2 high edge read");
    bus_cycle(20'hCFFFE, 0, 1, 1, 16'h5555, 8, 0, "R2 below window");
    bus_cycle(20'hE0000, 0, 1, 0, 16'h0, 8, 0, "R2 above window");
    bus_cycle(20'hD4000, 1, 1, 1, 16'h7777, 8, 0, "R3 aen high write");
    bus_cycle(20'hD4002, 1, 1, 0, 16'h0, 8, 0, "R3 aen high read");
    bus_cycle(20'hD0100, 0, 1, 1, 16'h0A0A, 8, 1, "R4 setup write");
    bus_cycle(20'hD0100, 0, 0, 1, 16'h0B0B, 8, 0, "R4 no fresh ale write");
    bus_cycle(20'hD0100, 0, 0, 0, 16'h0, 8, 0, "R4 no fresh ale read");
    bus_cycle(20'hD0011, 0, 1, 1, 16'h3333, 8, 0, "R11 odd write");
    bus_cycle(20'hD0013, 0, 1, 0, 16'h0, 8, 0, "R11 odd read");
    bus_cycle(20'hD8888, 0, 1, 0, 16'h0, 40, 1, "R10 long read strobe");
    bus_cycle(20'hD9998, 0, 1, 1, 16'h4321, 40, 1, "R10 long write strobe");
    bus_cycle(20'hD7776, 0, 1, 0, 16'h0, 8, 1, "R8 read after write");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule